// File: doc/BRIEF.md
# Limit-Compare Interval Timer

This block is a 32-bit up-counter with a compare register and a small control register, all reached through a simple write-strobe register bus with a combinational read port. Software arms it in three steps. It writes the ceiling, then the tally (normally zero), then the control word. While the run bit is set, the tally advances by one each clock. When it equals the ceiling, it returns to zero on the next running clock.

A match with the interrupt enable set latches a pending flag. The interrupt output is that flag gated by the enable. Any control write acknowledges the flag. Whether the next interval raises an interrupt again depends on whether that same write sets the enable bit, so the one write selects periodic or one-shot operation.

With the ceiling at all ones and the enable clear, the block serves as a free-running wraparound counter.

Top module: `interval_timer`

## Requirements
- R1: After reset the tally, ceiling and control register read zero and `irq` is low, so the timer starts halted.
- R2: The tally changes only while the run bit (control bit 1) is 1, unless software writes the tally.
- R3: While running, a tally equal to the ceiling becomes zero on the next clock, so one interval lasts ceiling+1 cycles.
- R4: A tally write (address 0) loads the write data on the next clock and takes priority over counting and wrapping. A match is not counted in the cycle of a tally write.
- R5: A running match with the enable bit (control bit 0) set sets the pending flag (control bit 3). A match with the enable clear leaves the pending flag unchanged.
- R6: A control write (address 2) loads the enable from data bit 0 and the run bit from data bit 1, and clears the pending flag. Data bit 3 can never set the flag.
- R7: When a control write and a running match with the enable set fall in the same cycle, the pending flag is 1 afterwards.
- R8: `irq` is high exactly when the pending flag and the enable bit are both 1.
- R9: With the ceiling at all ones, the run bit set and the enable clear, the tally goes from all ones to zero and `irq` stays low.
- R10: Reads return the tally at address 0, the ceiling at address 1, and at address 2 the control word with bit 0 enable, bit 1 run, bit 3 pending and all other bits zero. Address 3 reads zero. A ceiling write (address 1) loads the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the selected register |
| addr | input | 2 | Register select: 0 tally, 1 ceiling, 2 control |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the selected register (combinational) |
| irq | output | 1 | Level interrupt: pending AND enable |

## Verification
The assertions assume that `addr` and `wdata` hold known values whenever `wr_en` is high. They also assume a write affects only the register it selects.

The stimulus drives every input at the falling edge, so values are stable around each rising edge. Ceilings in the random phase are kept small (0 to 15) so that wraps, matches and collisions with control writes happen often. Directed sequences cover the all-ones wrap and an acknowledge that lands exactly on a match.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SEL_TALLY = 2'd0,
    SEL_CEIL  = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } tmr_sel_e;

  localparam int BIT_IE   = 0;
  localparam int BIT_RUN  = 1;
  localparam int BIT_PEND = 3;
  localparam int CTRL_USED = BIT_PEND + 1;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_pkg::*;
(
  input  logic       wr_en,
  input  logic [1:0] addr,
  output logic       wr_tally,
  output logic       wr_ceil,
  output logic       wr_ctrl
);
  tmr_sel_e sel;
  assign sel      = tmr_sel_e'(addr);
  assign wr_tally = wr_en && (sel == SEL_TALLY);
  assign wr_ceil  = wr_en && (sel == SEL_CEIL);
  assign wr_ctrl  = wr_en && (sel == SEL_CTRL);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_tally,
  input  logic         wr_ceil,
  input  logic         run,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] tally,
  output logic [W-1:0] ceil,
  output logic         hit
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  // step of a running counter: wrap at the ceiling, else increment
  function automatic logic [W-1:0] advance(input logic [W-1:0] cur,
                                           input logic [W-1:0] lim);
    return (cur == lim) ? '0 : cur + ONE;
  endfunction

  assign hit = run && (tally == ceil) && !wr_tally;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tally <= '0;
      ceil  <= '0;
    end else begin
      if (wr_tally)  tally <= wdata;
      else if (run)  tally <= advance(tally, ceil);
      if (wr_ceil)   ceil  <= wdata;
    end
  end
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic [1:0] ctrl_bits,
  input  logic       hit,
  output logic       ie,
  output logic       run,
  output logic       pend
);
  logic raise;
  assign raise = hit && ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie   <= 1'b0;
      run  <= 1'b0;
      pend <= 1'b0;
    end else if (wr_ctrl) begin
      ie   <= ctrl_bits[0];
      run  <= ctrl_bits[1];
      pend <= raise;
    end else begin
      pend <= pend || raise;
    end
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import tmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         irq
);
  localparam int PAD = W - CTRL_USED;

  logic         wr_tally, wr_ceil, wr_ctrl;
  logic [W-1:0] tally, ceil;
  logic         hit, ie, run, pend;
  logic [W-1:0] ctrl_word;

  tmr_decode u_dec (
    .wr_en(wr_en), .addr(addr),
    .wr_tally(wr_tally), .wr_ceil(wr_ceil), .wr_ctrl(wr_ctrl)
  );

  tmr_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .wr_tally(wr_tally), .wr_ceil(wr_ceil),
    .run(run), .wdata(wdata), .tally(tally), .ceil(ceil), .hit(hit)
  );

  tmr_flag u_flag (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl),
    .ctrl_bits(wdata[BIT_RUN:BIT_IE]), .hit(hit),
    .ie(ie), .run(run), .pend(pend)
  );

  assign ctrl_word = {{PAD{1'b0}}, pend, 1'b0, run, ie};

  always_comb begin
    case (tmr_sel_e'(addr))
      SEL_TALLY: rdata = tally;
      SEL_CEIL:  rdata = ceil;
      SEL_CTRL:  rdata = ctrl_word;
      default:   rdata = '0;
    endcase
  end

  assign irq = pend && ie;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_tally,
  input logic         wr_ctrl,
  input logic [W-1:0] wdata,
  input logic [W-1:0] tally,
  input logic [W-1:0] ceil,
  input logic         run,
  input logic         ie,
  input logic         pend,
  input logic         hit,
  input logic         irq
);
  a_r2_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_tally) |=> $stable(tally));

  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wr_tally && (tally == ceil)) |=> (tally == '0));

  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tally |=> (tally == $past(wdata)));

  a_r5_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ie) |=> pend);

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !(hit && ie)) |=> !pend);

  a_r8_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(hit));

  a_r8_irq_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ie && pend));
endmodule

bind interval_timer tmr_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_tally(wr_tally), .wr_ctrl(wr_ctrl),
  .wdata(wdata), .tally(tally), .ceil(ceil), .run(run), .ie(ie),
  .pend(pend), .hit(hit), .irq(irq)
);

// File: tb/tb_interval_timer.sv
`timescale 1ns/1ps
module tb_interval_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference state
  logic [31:0] m_cnt, m_lim;
  logic        m_ie, m_run, m_pend;

  always #2 clk = ~clk;

  interval_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return m_cnt;
      2'd1: return m_lim;
      2'd2: return {28'd0, m_pend, 1'b0, m_run, m_ie};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] a);
    case (a)
      2'd0: return "R3/R4 tally";
      2'd1: return "R10 ceiling";
      2'd2: return "R5/R6/R7 control";
      default: return "R10 unmapped";
    endcase
  endfunction

  task automatic model_tick(input logic we, input logic [1:0] a, input logic [31:0] d);
    logic hit;
    hit = m_run && (m_cnt == m_lim) && !(we && a == 2'd0);
    if (we && a == 2'd0)  m_cnt = d;
    else if (m_run)       m_cnt = (m_cnt == m_lim) ? 32'd0 : m_cnt + 32'd1;
    if (we && a == 2'd1)  m_lim = d;
    if (we && a == 2'd2) begin
      m_pend = hit && m_ie;
      m_ie   = d[0];
      m_run  = d[1];
    end else begin
      m_pend = m_pend || (hit && m_ie);
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: drive at falling edge, compare before the rising edge
  task automatic cycle(input logic we, input logic [1:0] a, input logic [31:0] d,
                       input bit do_chk);
    @(negedge clk);
    wr_en = we; addr = a; wdata = d;
    #1;
    if (do_chk) begin
      check(tag_of(a), rdata, exp_read(a));
      check("R8 irq", {31'd0, irq}, {31'd0, m_pend && m_ie});
    end
    @(posedge clk);
    model_tick(we, a, d);
  endtask

  task automatic rd(input logic [1:0] a);
    cycle(1'b0, a, 32'd0, 1'b1);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cycle(1'b1, a, d, 1'b0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    m_cnt = 0; m_lim = 0; m_ie = 0; m_run = 0; m_pend = 0;
    seed = $urandom(32'h5eed1234);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 tally", rdata, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    rd(2'd1); rd(2'd2); rd(2'd3); rd(2'd0);

    // R2: halted tally holds
    wr(2'd0, 32'd7);
    rd(2'd0); rd(2'd0);

    // R3/R5: periodic with ceiling 3, enable on
    wr(2'd1, 32'd3); wr(2'd0, 32'd0); wr(2'd2, 32'd3);
    for (int i = 0; i < 10; i++) rd(2'd0);
    rd(2'd2);
    // R6: acknowledge with bit 3 set and enable off, run kept
    wr(2'd2, 32'h0000_000A);
    rd(2'd2);
    for (int i = 0; i < 6; i++) rd(2'd2);

    // R7: acknowledge landing on a match
    wr(2'd2, 32'd3); wr(2'd0, 32'd3);
    wr(2'd2, 32'd3);
    rd(2'd2);

    // R9: free-running all-ones wrap without interrupt
    wr(2'd2, 32'd0); wr(2'd1, 32'hFFFF_FFFF); wr(2'd0, 32'hFFFF_FFFD);
    wr(2'd2, 32'd2);
    rd(2'd0); rd(2'd0); rd(2'd0); rd(2'd0);
    check("R9 irq low", {31'd0, irq}, 32'd0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      r = $urandom % 100;
      if (r < 8)       wr(2'd1, $urandom % 16);
      else if (r < 14) wr(2'd0, $urandom % 18);
      else if (r < 22) wr(2'd2, $urandom % 16);
      else if (r < 24) wr(2'd3, $urandom);
      else             rd(2'($urandom % 4));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule